// File: doc/BRIEF.md
# Dual Programmable PLL Ratio Dividers

This block sits in front of a phase detector in a frequency synthesizer. It divides a reference clock by one of four fixed ratios and an RF-derived clock by a programmable 15-bit ratio. Each divider emits a one-cycle pulse in its own clock domain once per period. A bus decoder outside the block stages the settings and marks every finished write by flipping a commit toggle. Each divider lane picks up new settings only when the phase detector reports that the charge pump is idle. This keeps a retune from cutting a comparison short.

Both counters stay silent after reset until a write carries a usable main ratio. From then on, a new ratio is applied at the counter's next terminal count, so no period is ever shortened. A test bit routes both divided streams to two monitor outputs.

The staged inputs (`refSel`, `mainRatio`) must be held steady from a commit until the next commit. Each lane samples them at its own load moment. The commit toggle and the pump flag each pass through a two-flop synchroniser in each lane's clock domain before use.

Top module: `pllDualDivider`

## Requirements
- R1: The reference divider period in `refClk` cycles follows `refSel` = {rd1, rd2}: 2'b00 gives 1120, 2'b01 gives 1024, 2'b10 gives 1152 and 2'b11 gives 1536.
- R2: The main divider period in `rfClk` cycles equals the unsigned value of `mainRatio`, for any value from 2048 up to 32767.
- R3: After reset, `refPulse` and `mainPulse` stay low until a commit arrives whose staged `mainRatio` is at least 2048. Once running, a divider never stops again.
- R4: A change to `refSel` or `mainRatio` has no effect on either period until `commitTgl` changes level.
- R5: While `pumpBusy` is high, committed settings wait and both periods keep their old values. They are applied once `pumpBusy` is low.
- R6: With `testEn` high, `refMon` equals `refPulse` and `mainMon` equals `mainPulse`. With `testEn` low, both monitor outputs are low.
- R7: Each divided output is high for exactly one cycle per period. A newly loaded ratio takes effect at the terminal count, so no period is shorter than the smaller of the old and new ratios.
- R8: A committed `mainRatio` below 2048 is ignored and the main divider keeps its previous ratio. The reference select carried by the same commit is still applied once the block is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| refClk | input | 1 | Reference clock, drives the reference divider |
| rfClk | input | 1 | RF-derived clock, drives the main divider |
| rstN | input | 1 | Active-low asynchronous reset for both lanes |
| refSel | input | 2 | Staged reference ratio select {rd1, rd2} |
| mainRatio | input | 15 | Staged main divide ratio |
| testEn | input | 1 | Routes divided streams to the monitor outputs |
| commitTgl | input | 1 | Flips once at the end of each completed bus write |
| pumpBusy | input | 1 | High while the charge pump sources or sinks current |
| refPulse | output | 1 | One-cycle pulse per reference period (refClk domain) |
| mainPulse | output | 1 | One-cycle pulse per main period (rfClk domain) |
| refMon | output | 1 | Test monitor copy of the reference pulse |
| mainMon | output | 1 | Test monitor copy of the main pulse |

## Verification
The bench builds the block with its default parameters: the four reference ratios 1120, 1024, 1152 and 1536, a 15-bit main counter and a floor of 2048. With these values every select code is measured against its exact period in cycles. The floor is probed from both sides, with 100 and 1000 below it and 2048 at it. The full-scale ratio 32767 is also reached. Two unrelated clock periods keep the synchronised commit and pump paths honest, and the run stays short enough to hold a pump stall across several full reference periods.

// File: rtl/pllDivPkg.sv
`timescale 1ns/1ps
package pllDivPkg;

  // Strobes from a lane controller to its counter datapath.
  typedef struct packed {
    logic load;   // copy the staged ratio into the live counter
    logic armed;  // the counter has left its post-reset hold
  } divStrobeT;

  function automatic int maxOf4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/pllDivCtrl.sv
`timescale 1ns/1ps
module pllDivCtrl
  import pllDivPkg::*;
#(
  parameter bit ARM_ONLY_GATE = 1'b0  // 1: the valid-word check only gates arming
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      commitTgl,
  input  logic      pumpBusy,
  input  logic      wordOk,
  output divStrobeT strb
);

  logic [2:0] commitSync;
  logic [1:0] pumpSync;
  logic       pending;
  logic       armed;
  logic       commitEdge;
  logic       pumpIdle;
  logic       fire;
  logic       accept;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      commitSync <= '0;
      pumpSync   <= '0;
    end else begin
      commitSync <= {commitSync[1:0], commitTgl};
      pumpSync   <= {pumpSync[0], pumpBusy};
    end
  end

  assign commitEdge = commitSync[2] ^ commitSync[1];
  assign pumpIdle   = ~pumpSync[1];
  assign fire       = pending & pumpIdle;

  generate
    if (ARM_ONLY_GATE) begin : gArmGate
      assign accept = armed | wordOk;
    end else begin : gWordGate
      assign accept = wordOk;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
      armed   <= 1'b0;
    end else begin
      if (commitEdge) pending <= 1'b1;
      else if (fire)  pending <= 1'b0;
      if (fire && accept) armed <= 1'b1;
    end
  end

  assign strb.load  = fire & accept;
  assign strb.armed = armed;

  // R5
  pending_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pending && pumpSync[1]) |=> pending);

  // R3
  armed_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    armed |=> armed);

endmodule

// File: rtl/pllDivCore.sv
`timescale 1ns/1ps
module pllDivCore
  import pllDivPkg::*;
#(
  parameter int W         = 15,
  parameter int MIN_RATIO = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  divStrobeT    strb,
  input  logic [W-1:0] ratioIn,
  output logic         pulse
);

  localparam logic [W-1:0] ONE   = W'(1);
  localparam logic [W-1:0] FLOOR = W'(MIN_RATIO);

  logic [W-1:0] ratioQ;
  logic [W-1:0] cnt;
  logic         atEnd;

  assign atEnd = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ratioQ <= '0;
      cnt    <= '0;
    end else begin
      if (strb.load) ratioQ <= ratioIn;
      if (strb.load && (!strb.armed || atEnd)) begin
        cnt <= ratioIn - ONE;
      end else if (strb.armed) begin
        cnt <= atEnd ? (ratioQ - ONE) : (cnt - ONE);
      end
    end
  end

  assign pulse = strb.armed & atEnd;

  // R7
  wrap_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.armed && atEnd && !strb.load) |=> (cnt == $past(ratioQ) - ONE));

  // R4
  ratio_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(ratioQ));

  // R8
  ratio_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.armed |-> (ratioQ >= FLOOR));

endmodule

// File: rtl/pllDualDivider.sv
`timescale 1ns/1ps
module pllDualDivider
  import pllDivPkg::*;
#(
  parameter int REF_DIV_0 = 1120,  // select 2'b00
  parameter int REF_DIV_1 = 1024,  // select 2'b01
  parameter int REF_DIV_2 = 1152,  // select 2'b10
  parameter int REF_DIV_3 = 1536,  // select 2'b11
  parameter int MAIN_W    = 15,
  parameter int MAIN_MIN  = 2048
) (
  input  logic              refClk,
  input  logic              rfClk,
  input  logic              rstN,
  input  logic [1:0]        refSel,
  input  logic [MAIN_W-1:0] mainRatio,
  input  logic              testEn,
  input  logic              commitTgl,
  input  logic              pumpBusy,
  output logic              refPulse,
  output logic              mainPulse,
  output logic              refMon,
  output logic              mainMon
);

  localparam int REF_MAX = maxOf4(REF_DIV_0, REF_DIV_1, REF_DIV_2, REF_DIV_3);
  localparam int REF_W   = $clog2(REF_MAX + 1);
  localparam int REF_MIN_ALL = (REF_DIV_0 < REF_DIV_1 ? REF_DIV_0 : REF_DIV_1) <
                               (REF_DIV_2 < REF_DIV_3 ? REF_DIV_2 : REF_DIV_3) ?
                               (REF_DIV_0 < REF_DIV_1 ? REF_DIV_0 : REF_DIV_1) :
                               (REF_DIV_2 < REF_DIV_3 ? REF_DIV_2 : REF_DIV_3);
  localparam logic [MAIN_W-1:0] MAIN_FLOOR = MAIN_W'(MAIN_MIN);

  logic             mainWordOk;
  logic [REF_W-1:0] refRatio;
  divStrobeT        refStrb;
  divStrobeT        mainStrb;

  assign mainWordOk = (mainRatio >= MAIN_FLOOR);

  always_comb begin
    unique case (refSel)
      2'b00:   refRatio = REF_W'(REF_DIV_0);
      2'b01:   refRatio = REF_W'(REF_DIV_1);
      2'b10:   refRatio = REF_W'(REF_DIV_2);
      default: refRatio = REF_W'(REF_DIV_3);
    endcase
  end

  // Reference lane: a valid main word is needed only to leave reset hold.
  pllDivCtrl #(.ARM_ONLY_GATE(1'b1)) uRefCtrl (
    .clk       (refClk),
    .rstN      (rstN),
    .commitTgl (commitTgl),
    .pumpBusy  (pumpBusy),
    .wordOk    (mainWordOk),
    .strb      (refStrb)
  );

  pllDivCore #(.W(REF_W), .MIN_RATIO(REF_MIN_ALL)) uRefCore (
    .clk     (refClk),
    .rstN    (rstN),
    .strb    (refStrb),
    .ratioIn (refRatio),
    .pulse   (refPulse)
  );

  // Main lane: every load requires a word at or above the floor.
  pllDivCtrl #(.ARM_ONLY_GATE(1'b0)) uMainCtrl (
    .clk       (rfClk),
    .rstN      (rstN),
    .commitTgl (commitTgl),
    .pumpBusy  (pumpBusy),
    .wordOk    (mainWordOk),
    .strb      (mainStrb)
  );

  pllDivCore #(.W(MAIN_W), .MIN_RATIO(MAIN_MIN)) uMainCore (
    .clk     (rfClk),
    .rstN    (rstN),
    .strb    (mainStrb),
    .ratioIn (mainRatio),
    .pulse   (mainPulse)
  );

  assign refMon  = testEn & refPulse;
  assign mainMon = testEn & mainPulse;

endmodule

// File: tb/pllDualDivider_test.sv
`timescale 1ns/1ps
module pllDualDivider_test;

  logic        refClk = 1'b0;
  logic        rfClk  = 1'b0;
  logic        rstN;
  logic [1:0]  refSel;
  logic [14:0] mainRatio;
  logic        testEn;
  logic        commitTgl;
  logic        pumpBusy;
  logic        refPulse, mainPulse, refMon, mainMon;

  int checks = 0;
  int failures = 0;

  int    refExp[$];
  string refTag[$];
  int    mainExp[$];
  string mainTag[$];

  int refCyc = 0, mainCyc = 0, refLast = 0, mainLast = 0;
  bit refSeen = 0, mainSeen = 0, refPrev = 0, mainPrev = 0;
  int refTotal = 0, mainTotal = 0, dblPulse = 0;
  int refMinGap = 1 << 30, mainMinGap = 1 << 30;
  int monLowBad = 0, monCopyBad = 0, monHits = 0;
  int mainLive = 0;
  bit done = 0;

  always #5 refClk = ~refClk;   // 100 MHz
  always #3 rfClk  = ~rfClk;

  pllDualDivider uut (
    .refClk(refClk), .rfClk(rfClk), .rstN(rstN), .refSel(refSel),
    .mainRatio(mainRatio), .testEn(testEn), .commitTgl(commitTgl),
    .pumpBusy(pumpBusy), .refPulse(refPulse), .mainPulse(mainPulse),
    .refMon(refMon), .mainMon(mainMon)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference-domain monitor
  always @(negedge refClk) begin
    refCyc++;
    if (refPulse) begin
      refTotal++;
      if (refSeen) begin
        if (refCyc - refLast < refMinGap) refMinGap = refCyc - refLast;
        if (refExp.size() > 0) begin
          int e;
          string t;
          e = refExp.pop_front();
          t = refTag.pop_front();
          check((refCyc - refLast) == e, t, refCyc - refLast, e);
        end
      end
      refSeen = 1;
      refLast = refCyc;
    end
    if (refPulse && refPrev) dblPulse++;
    refPrev = refPulse;
    if (testEn) begin
      if (refMon !== refPulse) monCopyBad++;
      if (refMon) monHits++;
    end else if (refMon !== 1'b0) monLowBad++;
  end

  // Main-domain monitor
  always @(negedge rfClk) begin
    mainCyc++;
    if (mainPulse) begin
      mainTotal++;
      if (mainSeen) begin
        if (mainCyc - mainLast < mainMinGap) mainMinGap = mainCyc - mainLast;
        if (mainExp.size() > 0) begin
          int e;
          string t;
          e = mainExp.pop_front();
          t = mainTag.pop_front();
          check((mainCyc - mainLast) == e, t, mainCyc - mainLast, e);
        end
      end
      mainSeen = 1;
      mainLast = mainCyc;
    end
    if (mainPulse && mainPrev) dblPulse++;
    mainPrev = mainPulse;
    if (testEn) begin
      if (mainMon !== mainPulse) monCopyBad++;
      if (mainMon) monHits++;
    end else if (mainMon !== 1'b0) monLowBad++;
  end

  task automatic writeCfg(input logic [1:0] sel, input int ratio, input bit tst);
    @(negedge refClk);
    #1;
    refSel    = sel;
    mainRatio = ratio[14:0];
    testEn    = tst;
    #20;
    commitTgl = ~commitTgl;
  endtask

  // Driver: wait until the lanes settle, then queue expected periods.
  task automatic expectPeriods(input int refN, input int mainN, input int cnt,
                               input string rTag, input string mTag);
    int hi;
    hi = (mainLive > mainN) ? mainLive : mainN;
    #(16000 + (hi + 60) * 6);
    @(posedge refClk);
    for (int i = 0; i < cnt; i++) begin
      refExp.push_back(refN);
      refTag.push_back(rTag);
      mainExp.push_back(mainN);
      mainTag.push_back(mTag);
    end
    mainLive = mainN;
    while (refExp.size() > 0 || mainExp.size() > 0) @(posedge refClk);
  endtask

  initial begin
    rstN = 1'b0; refSel = 2'b00; mainRatio = '0; testEn = 1'b0;
    commitTgl = 1'b0; pumpBusy = 1'b0;
    #52 rstN = 1'b1;
    #2;
    // R3: reset state of all outputs
    check({refPulse, mainPulse, refMon, mainMon} == 4'b0000, "R3 reset outputs",
          {refPulse, mainPulse, refMon, mainMon}, 0);
    #20000;
    check(refTotal == 0, "R3 ref silent before any write", refTotal, 0);
    check(mainTotal == 0, "R3 main silent before any write", mainTotal, 0);

    // R8/R3: a sub-floor first word leaves both counters held
    writeCfg(2'b00, 1000, 0);
    #30000;
    check(refTotal == 0, "R8 ref held after low first word", refTotal, 0);
    check(mainTotal == 0, "R8 main held after low first word", mainTotal, 0);

    // R1/R2: each reference select and several main ratios
    writeCfg(2'b00, 2048, 0);
    mainLive = 2048;
    expectPeriods(1120, 2048, 2, "R1 sel00 period", "R2 main 2048 period");
    writeCfg(2'b10, 3000, 0);
    expectPeriods(1152, 3000, 2, "R1 sel10 period", "R2 main 3000 period");
    writeCfg(2'b01, 3000, 0);
    expectPeriods(1024, 3000, 2, "R1 sel01 period", "R2 main 3000 kept");
    writeCfg(2'b11, 3000, 0);
    expectPeriods(1536, 3000, 2, "R1 sel11 period", "R2 main 3000 kept");

    // R8: low main word ignored, reference select still applied
    writeCfg(2'b00, 100, 0);
    expectPeriods(1120, 3000, 2, "R8 ref select applied", "R8 main ratio kept");

    // R4: staged change without a commit has no effect
    @(negedge refClk);
    #1;
    refSel = 2'b11;
    mainRatio = 15'd4000;
    expectPeriods(1120, 3000, 2, "R4 ref unchanged without commit",
                  "R4 main unchanged without commit");

    // R5: pump busy defers the load
    pumpBusy = 1'b1;
    #200;
    writeCfg(2'b01, 2500, 0);
    expectPeriods(1120, 3000, 2, "R5 ref held while pump busy",
                  "R5 main held while pump busy");
    mainLive = 3000;
    pumpBusy = 1'b0;
    expectPeriods(1024, 2500, 2, "R5 ref applied after pump idle",
                  "R5 main applied after pump idle");

    // R6: monitors low while test is off
    check(monLowBad == 0, "R6 monitors low with test off", monLowBad, 0);
    writeCfg(2'b01, 2500, 1);
    expectPeriods(1024, 2500, 2, "R6 ref period in test", "R6 main period in test");
    check(monCopyBad == 0, "R6 monitors follow pulses", monCopyBad, 0);
    check(monHits > 0, "R6 monitor pulses seen", monHits, 1);

    // R2: full-scale main ratio
    writeCfg(2'b01, 32767, 0);
    expectPeriods(1024, 32767, 1, "R1 sel01 with full-scale main",
                  "R2 main 32767 period");

    // R7: one-cycle pulses and no runt periods
    check(dblPulse == 0, "R7 single-cycle pulses", dblPulse, 0);
    check(refMinGap >= 1024, "R7 no short ref period", refMinGap, 1024);
    check(mainMinGap >= 2048, "R7 no short main period", mainMinGap, 2048);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge refClk);
    if (!done) begin
      done = 1;
      check(1'b0, "R2 watchdog expired", 195000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule